// File: doc/BRIEF.md
# DES Round-Key Expander

This block turns one 64-bit DES key into the full set of sixteen 48-bit round keys at once. It has no rotating key register and no shifters. Each round key is a fixed selection of key input bits. The selections are worked out at elaboration time from the two standard permuted-choice tables and the rotation schedule, and the result is plain wiring.

A pipelined cipher core needs the round keys for all of its stages at the same time. The optional output register launches all sixteen round keys from flops on the same edge, so the core sees them together and a new key can be accepted every clock cycle. With the register turned off, the block is purely combinational.

Top module: `des_keyfan`

## Requirements
- R1: The eight parity bits are the least significant bit of each byte of `key_i` (bits 0, 8, 16, ..., 56). Changing them has no effect on any round key.
- R2: Slice `subkeys_o[i]` holds the key for round i+1, so index 0 is round 1 and index 15 is round 16. Within each slice, bit 47 is the first bit of the round key in standard numbering. In `key_i`, bit 63 is key bit 1.
- R3: Every round key matches the standard schedule. The 56 non-parity bits pass through permuted choice 1 and split into two 28-bit halves. For round r, both halves are rotated left by the cumulative total of the per-round amounts 1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1. Permuted choice 2 is then applied.
- R4: For key 0x133457799BBCDFF1, round 1 is 0x1B02EFFC7072 and round 16 is 0xCB3D8B0E17F5.
- R5: With `OUT_REG`=1, the round keys for a key sampled at a clock edge appear after that edge. A different key may be applied on every cycle.
- R6: While `key_i` holds steady, the round keys do not change.
- R7: With `OUT_REG`=1, `rst_n` low clears every output bit to 0 asynchronously, and the outputs stay 0 until the first edge after release.
- R8: If all 56 non-parity key bits are 0, every round key is all zeros. If all 56 are 1, every round key is all ones.
- R9: If exactly one non-parity key bit is set, each round key has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| key_i | input | 64 | Key including parity bits, bit 63 = key bit 1 |
| subkeys_o | output | 16x48 | Round keys, index 0 = round 1 |

## Verification
The hardest part to reach from the ports is proving that every one of the 768 output bits is routed from the correct key bit for its round. A wrong rotation total for a single round can hide behind keys whose bit patterns repeat. The bench therefore walks a single set bit across all 56 non-parity positions, where a misroute moves or removes a lone one. It adds a long run of back-to-back keys from an LFSR, compared against an iterative rotate-and-select model. Parity independence is exercised by XOR-ing parity patterns onto a fixed key and expecting the unmodified result.

// File: rtl/des_keyfan.sv
module des_keyfan #(
  parameter bit OUT_REG = 1'b1,
  parameter int ROUNDS  = 16,
  parameter int KW      = 64,
  parameter int SKW     = 48
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [KW-1:0]             key_i,
  output logic [ROUNDS-1:0][SKW-1:0] subkeys_o
);
  localparam int HALF = 28;
  localparam logic [KW-1:0] PAR_MASK = 64'h0101_0101_0101_0101;

  localparam int SEL1 [56] = '{57,49,41,33,25,17, 9, 1,58,50,42,34,26,18,
                               10, 2,59,51,43,35,27,19,11, 3,60,52,44,36,
                               63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
                               14, 6,61,53,45,37,29,21,13, 5,28,20,12, 4};
  localparam int SEL2 [48] = '{14,17,11,24, 1, 5, 3,28,15, 6,21,10,
                               23,19,12, 4,26, 8,16, 7,27,20,13, 2,
                               41,52,31,37,47,55,30,40,51,45,33,48,
                               44,49,39,56,34,53,46,42,50,36,29,32};

  function automatic int rot_total(int r);
    int s = 0;
    for (int i = 0; i <= r; i++)
      s += (i == 0 || i == 1 || i == 8 || i == 15) ? 1 : 2;
    return s;
  endfunction

  function automatic int key_pos(int r, int m);
    int s = rot_total(r);
    int p = SEL2[m];
    int q;
    if (p <= HALF) q = ((p - 1 + s) % HALF) + 1;
    else           q = ((p - HALF - 1 + s) % HALF) + HALF + 1;
    return SEL1[q-1];
  endfunction

  logic [ROUNDS-1:0][SKW-1:0] sk_c;

  for (genvar r = 0; r < ROUNDS; r++) begin : g_round
    for (genvar m = 0; m < SKW; m++) begin : g_bit
      localparam int SRC = key_pos(r, m);
      assign sk_c[r][SKW-1-m] = key_i[KW-SRC];
    end
  end

  if (OUT_REG) begin : g_reg
    logic [ROUNDS-1:0][SKW-1:0] sk_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sk_q <= '0;
      else        sk_q <= sk_c;
    assign subkeys_o = sk_q;

    logic [ROUNDS-1:0] lone;
    for (genvar r = 0; r < ROUNDS; r++) begin : g_lone
      assign lone[r] = $onehot0(subkeys_o[r]);
    end

    p_reset_zero_r7: assert property (@(posedge clk)
      !rst_n |=> subkeys_o == '0);

    p_parity_blind_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (((key_i ^ $past(key_i)) & ~PAR_MASK) == '0)) |=> $stable(subkeys_o));

    p_uniform_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (((key_i & ~PAR_MASK) == '0) || ((key_i | PAR_MASK) == '1))
        |=> (subkeys_o == '0 || subkeys_o == '1));

    p_single_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(key_i & ~PAR_MASK) == 1) |=> (&lone));
  end else begin : g_comb
    assign subkeys_o = sk_c;
  end
endmodule

// File: tb/tb_des_keyfan.sv
module tb_des_keyfan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] key_i = 64'h0;
  logic [15:0][47:0] subkeys_o;

  des_keyfan dut (.clk(clk), .rst_n(rst_n), .key_i(key_i), .subkeys_o(subkeys_o));

  always #2.5 clk = ~clk;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [767:0] exp_q[$];
  string tag_q[$];

  localparam int T1 [56] = '{57,49,41,33,25,17, 9, 1,58,50,42,34,26,18,
                             10, 2,59,51,43,35,27,19,11, 3,60,52,44,36,
                             63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
                             14, 6,61,53,45,37,29,21,13, 5,28,20,12, 4};
  localparam int T2 [48] = '{14,17,11,24, 1, 5, 3,28,15, 6,21,10,
                             23,19,12, 4,26, 8,16, 7,27,20,13, 2,
                             41,52,31,37,47,55,30,40,51,45,33,48,
                             44,49,39,56,34,53,46,42,50,36,29,32};

  function automatic logic [767:0] model(logic [63:0] k);
    logic [55:0] cd;
    logic [27:0] c, d;
    logic [767:0] res = '0;
    for (int j = 0; j < 56; j++) cd[55-j] = k[64-T1[j]];
    c = cd[55:28];
    d = cd[27:0];
    for (int r = 0; r < 16; r++) begin
      int amt = (r == 0 || r == 1 || r == 8 || r == 15) ? 1 : 2;
      for (int a = 0; a < amt; a++) begin
        c = {c[26:0], c[27]};
        d = {d[26:0], d[27]};
      end
      cd = {c, d};
      for (int m = 0; m < 48; m++) res[r*48 + 47 - m] = cd[56-T2[m]];
    end
    return res;
  endfunction

  task automatic check(string tag, logic [767:0] act, logic [767:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [63:0] k, logic [767:0] exp, string tag);
    @(negedge clk);
    key_i = k;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && exp_q.size() != 0) check(tag_q.pop_front(), subkeys_o, exp_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : driver
    logic [63:0] lf;
    logic [63:0] base;
    key_i = 64'h133457799BBCDFF1;
    repeat (3) @(negedge clk);
    check("R7 reset", subkeys_o, '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R7 after release", subkeys_o, '0);

    send(64'h133457799BBCDFF1, model(64'h133457799BBCDFF1), "R3 known");
    drain();
    @(posedge clk); #2;
    check("R4 round1", {720'b0, subkeys_o[0]}, {720'b0, 48'h1B02EFFC7072});
    check("R2 round16", {720'b0, subkeys_o[15]}, {720'b0, 48'hCB3D8B0E17F5});

    base = 64'h0E329232EA6D0D73;
    for (int i = 0; i < 8; i++) begin
      logic [63:0] pm = 64'h0;
      for (int b = 0; b < 8; b++) if (((i * 37 + b) % 3) == 0) pm[b*8] = 1'b1;
      send(base ^ pm, model(base), "R1 parity");
    end
    send(64'hFFFFFFFFFFFFFFFF ^ 64'h0101010101010101, model(64'hFFFFFFFFFFFFFFFF), "R1 parity only");

    send(64'h0000000000000000, '0, "R8 zeros");
    send(64'h0101010101010101, '0, "R8 parity set zeros");
    send(64'hFEFEFEFEFEFEFEFE, '1, "R8 ones");
    send(64'hFFFFFFFFFFFFFFFF, '1, "R8 ones parity");

    for (int i = 0; i < 4; i++) send(64'hA5A55A5AC3C33C3C, model(64'hA5A55A5AC3C33C3C), "R6 hold");

    for (int p = 0; p < 64; p++) begin
      if ((p % 8) != 0) send(64'h1 << p, model(64'h1 << p), "R9 walk");
    end

    lf = 64'hDEADBEEF01234567;
    for (int i = 0; i < 200; i++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      send(lf, model(lf), "R5 stream");
    end
    drain();
    @(posedge clk); #2;

    @(negedge clk);
    key_i = 64'h0123456789ABCDEF;
    rst_n = 1'b0;
    #1;
    check("R7 async", subkeys_o, '0);
    @(negedge clk);
    check("R7 held", subkeys_o, '0);
    rst_n = 1'b1;
    send(64'h0123456789ABCDEF, model(64'h0123456789ABCDEF), "R3 after reset");
    drain();
    @(posedge clk); #2;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule